// File: doc/BRIEF.md
# Flow-Controlled Double-Buffered Serial Transmitter

This block sends bytes as asynchronous serial frames. A holding register takes each byte from a one-cycle write strobe. A separate shift register drives the line, so the next byte can be written while the current one is still going out. A baud tick input paces the line. Every bit lasts a fixed number of ticks, set by a parameter that defaults to 16.

A new frame is admitted only at a frame boundary, which means the line is idle or the last stop tick is ending. At that boundary the enable bit must be set, the holding register must contain a byte, and the clear-to-send line must permit it. The clear-to-send line counts only when hardware flow control is on and the CTS-input mode is chosen. Once a frame has begun, it runs to completion whatever these inputs do.

Two status flags tell software where the block stands: one for the holding register and one for the whole transmitter. A single-cycle interrupt pulse fires whenever the holding register is handed to the shifter.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset the outputs are as follows: `txd` is 1, `buf_empty` is 1, `tx_empty` is 1 and `irq` is 0.
- R2: A frame consists of a 0 start bit, then 8 data bits with the least significant bit first, then one stop bit at 1. Each bit lasts exactly 16 baud ticks. While `baud_tick` stays 0, the line holds its current bit.
- R3: If `parity_en` is 1 when the frame starts, an even-parity bit follows data bit 7. That bit is the XOR of the 8 data bits.
- R4: A write with `wr_en` clears `buf_empty` from the next cycle. Moving the byte into the shifter sets `buf_empty` to 1. A write while the buffer is still full replaces the pending byte.
- R5: A frame starts only when three conditions hold at a frame boundary: `tx_enable` is 1, `buf_empty` is 0, and the flow-control condition of R6 holds. The start bit appears on `txd` in the cycle after the clock edge at which these conditions hold.
- R6: `cts_n` must be 0 to start a frame when `cts_sel` is 0 and `flow_off` is 0. When `cts_sel` is 1 or `flow_off` is 1, `cts_n` has no effect.
- R7: During a frame, changes on `tx_enable`, `cts_n` and the buffer do not alter or abort the frame.
- R8: If the buffer is refilled before the stop bit ends, the next start bit follows the 16 stop ticks directly, with no idle cycle. `tx_empty` stays 0 across the boundary.
- R9: `tx_empty` goes to 0 in the first start-bit cycle. It returns to 1 in the cycle after the last stop-bit cycle when no further frame starts.
- R10: `irq` is high for exactly one cycle. That cycle is the first one in which `buf_empty` reads 1 after having been 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | One-cycle strobe that writes `wr_data` into the holding register |
| wr_data | input | 8 | Byte to transmit |
| tx_enable | input | 1 | Transmit enable |
| cts_sel | input | 1 | Selects the flow-control mode: 0 means CTS input, 1 means RTS mode, in which CTS is ignored |
| flow_off | input | 1 | 1 turns hardware flow control off |
| parity_en | input | 1 | 1 appends an even-parity bit |
| baud_tick | input | 1 | One-cycle tick at 16 times the bit rate |
| cts_n | input | 1 | Clear-to-send input, active low |
| txd | output | 1 | Serial line output, 1 when idle |
| buf_empty | output | 1 | 1 when the holding register has no pending byte |
| tx_empty | output | 1 | 1 when no frame is in progress and none is starting |
| irq | output | 1 | One-cycle pulse when `buf_empty` rises |

## Verification
The bench runs the frame path with a table of byte values, both with and without parity. The values include all-zero, all-one, alternating and single-bit patterns, so that a bit-order error, a wrong parity sense or a lost stop bit each shows up as a different decode mismatch.

Directed cases cover the following:
- holding the enable low with two writes, which separates a correct overwrite from a stale byte;
- CTS held high in CTS mode, compared with RTS mode and with flow control off, which separates a correct gating from a missing one or an inverted one;
- inputs changed mid-frame;
- a refill during the stop bit, which tells back-to-back framing apart from an idle gap;
- a stalled baud tick, which proves that bit timing counts ticks and not clocks.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_START  = 3'd1,
    S_DATA   = 3'd2,
    S_PARITY = 3'd3,
    S_STOP   = 3'd4
  } tx_state_e;
endpackage

// File: rtl/uart_tx_holdreg.sv
`timescale 1ns/1ps
// Holding register with empty flag and rise-edge interrupt pulse.
module uart_tx_holdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              empty,
  output logic              irq
);
  logic [DATA_W-1:0] data_q, data_d;
  logic              empty_q, empty_d;
  logic              irq_q, irq_d;

  always_comb begin
    data_d  = data_q;
    empty_d = empty_q;
    if (take)  empty_d = 1'b1;
    if (wr_en) begin
      data_d  = wr_data;
      empty_d = 1'b0;
    end
    irq_d = empty_d & ~empty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      empty_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      if (wr_en) data_q <= data_d;
      empty_q <= empty_d;
      irq_q   <= irq_d;
    end
  end

  assign hold_data = data_q;
  assign empty     = empty_q;
  assign irq       = irq_q;
endmodule

// File: rtl/uart_tx_shifter.sv
`timescale 1ns/1ps
// Frame sequencer: start, data LSB first, optional even parity, stop.
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              parity_en,
  output logic              txd,
  output logic              frame_end
);
  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_W - 1);

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  tcnt_q, tcnt_d;
  logic [BIT_W-1:0]  bcnt_q, bcnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              pen_q, pen_d;
  logic              bit_done;
  logic              adv;

  assign bit_done = tick && (tcnt_q == LAST_TICK);
  assign adv      = tick | load;

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bcnt_d  = bcnt_q;
    sh_d    = sh_q;
    par_d   = par_q;
    pen_d   = pen_q;
    if (state_q != S_IDLE && tick) tcnt_d = tcnt_q + 1'b1;
    case (state_q)
      S_IDLE: begin
        if (load) begin
          state_d = S_START;
          tcnt_d  = '0;
          sh_d    = load_data;
          par_d   = ^load_data;
          pen_d   = parity_en;
        end
      end
      S_START: begin
        if (bit_done) begin
          state_d = S_DATA;
          bcnt_d  = '0;
          tcnt_d  = '0;
        end
      end
      S_DATA: begin
        if (bit_done) begin
          tcnt_d = '0;
          sh_d   = sh_q >> 1;
          if (bcnt_q == LAST_BIT) state_d = pen_q ? S_PARITY : S_STOP;
          else                    bcnt_d  = bcnt_q + 1'b1;
        end
      end
      S_PARITY: begin
        if (bit_done) begin
          state_d = S_STOP;
          tcnt_d  = '0;
        end
      end
      S_STOP: begin
        if (bit_done) begin
          tcnt_d = '0;
          if (load) begin
            state_d = S_START;
            sh_d    = load_data;
            par_d   = ^load_data;
            pen_d   = parity_en;
          end else begin
            state_d = S_IDLE;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      pen_q   <= 1'b0;
    end else if (adv) begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bcnt_q  <= bcnt_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      pen_q   <= pen_d;
    end
  end

  always_comb begin
    case (state_q)
      S_START:  txd = 1'b0;
      S_DATA:   txd = sh_q[0];
      S_PARITY: txd = par_q;
      default:  txd = 1'b1;
    endcase
  end

  assign frame_end = (state_q == S_IDLE) | ((state_q == S_STOP) & bit_done);
endmodule

// File: rtl/uart_tx_start_gate.sv
`timescale 1ns/1ps
// Start condition and transmitter-empty flag.
module uart_tx_start_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic tx_enable,
  input  logic buf_empty,
  input  logic cts_sel,
  input  logic flow_off,
  input  logic cts_n,
  output logic start,
  output logic tx_empty
);
  logic cts_ok;
  logic temp_q, temp_d;

  assign cts_ok = flow_off | cts_sel | ~cts_n;
  assign start  = frame_end & tx_enable & ~buf_empty & cts_ok;

  always_comb begin
    temp_d = temp_q;
    if (start)          temp_d = 1'b0;
    else if (frame_end) temp_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) temp_q <= 1'b1;
    else        temp_q <= temp_d;
  end

  assign tx_empty = temp_q;
endmodule

// File: rtl/uart_tx_flow.sv
`timescale 1ns/1ps
module uart_tx_flow #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_enable,
  input  logic              cts_sel,
  input  logic              flow_off,
  input  logic              parity_en,
  input  logic              baud_tick,
  input  logic              cts_n,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_empty,
  output logic              irq
);
  logic [DATA_W-1:0] hold_data;
  logic              start;
  logic              frame_end;

  uart_tx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .take      (start),
    .hold_data (hold_data),
    .empty     (buf_empty),
    .irq       (irq)
  );

  uart_tx_start_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .tx_enable (tx_enable),
    .buf_empty (buf_empty),
    .cts_sel   (cts_sel),
    .flow_off  (flow_off),
    .cts_n     (cts_n),
    .start     (start),
    .tx_empty  (tx_empty)
  );

  uart_tx_shifter #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .load      (start),
    .load_data (hold_data),
    .parity_en (parity_en),
    .txd       (txd),
    .frame_end (frame_end)
  );
endmodule

// File: rtl/uart_tx_flow_chk.sv
`timescale 1ns/1ps
module uart_tx_flow_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic tx_enable,
  input logic cts_sel,
  input logic flow_off,
  input logic cts_n,
  input logic txd,
  input logic buf_empty,
  input logic tx_empty,
  input logic irq
);
  p_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !buf_empty);

  p_load_starts_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> !txd);

  p_start_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(txd) && $past(tx_empty)) |-> ($past(tx_enable) && !$past(buf_empty)));

  p_cts_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(txd) && $past(tx_empty)) |-> (!$past(cts_n) || $past(cts_sel) || $past(flow_off)));

  p_busy_not_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !txd |-> !tx_empty);

  p_irq_needs_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $rose(buf_empty));

  p_rise_gives_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> irq);
endmodule

bind uart_tx_flow uart_tx_flow_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .tx_enable (tx_enable),
  .cts_sel   (cts_sel),
  .flow_off  (flow_off),
  .cts_n     (cts_n),
  .txd       (txd),
  .buf_empty (buf_empty),
  .tx_empty  (tx_empty),
  .irq       (irq)
);

// File: tb/uart_tx_flow_tb_top.sv
`timescale 1ns/1ps
module uart_tx_flow_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tx_enable = 1'b0;
  logic       cts_sel = 1'b0;
  logic       flow_off = 1'b1;
  logic       parity_en = 1'b0;
  logic       baud_tick = 1'b1;
  logic       cts_n = 1'b1;
  logic       txd, buf_empty, tx_empty, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  uart_tx_flow dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tx_enable(tx_enable), .cts_sel(cts_sel), .flow_off(flow_off),
    .parity_en(parity_en), .baud_tick(baud_tick), .cts_n(cts_n),
    .txd(txd), .buf_empty(buf_empty), .tx_empty(tx_empty), .irq(irq)
  );

  // {parity_en, data}
  localparam logic [8:0] VEC [8] = '{
    9'h0_55, 9'h0_00, 9'h0_FF, 9'h0_01,
    9'h1_80, 9'h1_A7, 9'h1_00, 9'h1_6E
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic get_frame(input logic [7:0] exp_d, input bit with_par, input bit b2b);
    int waitc = 0;
    logic [7:0] d = '0;
    while (txd !== 1'b0 && waitc < 600) begin
      @(negedge clk);
      waitc++;
    end
    chk(txd === 1'b0, "R5", "start bit seen", txd, 0);
    chk(irq === 1'b1, "R10", "irq on load", irq, 1);
    chk(buf_empty === 1'b1, "R4", "empty after load", buf_empty, 1);
    chk(tx_empty === 1'b0, "R9", "tx_empty at start", tx_empty, 0);
    repeat (8) @(negedge clk);
    chk(txd === 1'b0, "R2", "start bit mid", txd, 0);
    chk(irq === 1'b0, "R10", "irq single cycle", irq, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (16) @(negedge clk);
      d[i] = txd;
    end
    chk(d === exp_d, "R2", "data byte", d, exp_d);
    if (with_par) begin
      repeat (16) @(negedge clk);
      chk(txd === ^exp_d, "R3", "even parity", txd, ^exp_d);
    end
    repeat (16) @(negedge clk);
    chk(txd === 1'b1, "R2", "stop bit", txd, 1);
    repeat (7) @(negedge clk);
    chk(tx_empty === 1'b0, "R9", "tx_empty in last stop cycle", tx_empty, 0);
    @(negedge clk);
    if (b2b) begin
      chk(txd === 1'b0, "R8", "next start without gap", txd, 0);
      chk(tx_empty === 1'b0, "R8", "tx_empty held low", tx_empty, 0);
    end else begin
      chk(tx_empty === 1'b1, "R9", "tx_empty after frame", tx_empty, 1);
      chk(txd === 1'b1, "R1", "idle line", txd, 1);
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1, "R1", "txd in reset", txd, 1);
    chk(buf_empty === 1'b1, "R1", "buf_empty in reset", buf_empty, 1);
    chk(tx_empty === 1'b1, "R1", "tx_empty in reset", tx_empty, 1);
    chk(irq === 1'b0, "R1", "irq in reset", irq, 0);
    rst_n = 1'b1;
    tx_enable = 1'b1;
    repeat (2) @(negedge clk);

    // Table of frames: R2, R3
    for (int v = 0; v < 8; v++) begin
      parity_en = VEC[v][8];
      write_byte(VEC[v][7:0]);
      chk(buf_empty === 1'b0, "R4", "write clears empty", buf_empty, 0);
      get_frame(VEC[v][7:0], VEC[v][8], 1'b0);
      repeat (3) @(negedge clk);
    end
    parity_en = 1'b0;

    // R4 overwrite while held, R5 start latency
    tx_enable = 1'b0;
    write_byte(8'h3C);
    write_byte(8'hA5);
    repeat (20) @(negedge clk);
    chk(txd === 1'b1, "R5", "no start while disabled", txd, 1);
    chk(buf_empty === 1'b0, "R4", "still full", buf_empty, 0);
    tx_enable = 1'b1;
    @(negedge clk);
    chk(txd === 1'b0, "R5", "start one cycle after enable", txd, 0);
    get_frame(8'hA5, 1'b0, 1'b0);

    // R6 CTS gating, R7 mid-frame changes ignored
    flow_off = 1'b0;
    cts_sel = 1'b0;
    cts_n = 1'b1;
    write_byte(8'h5A);
    repeat (30) @(negedge clk);
    chk(txd === 1'b1, "R6", "held by CTS high", txd, 1);
    chk(buf_empty === 1'b0, "R6", "byte still pending", buf_empty, 0);
    cts_n = 1'b0;
    parity_en = 1'b1;
    fork
      get_frame(8'h5A, 1'b1, 1'b0);
      begin
        repeat (40) @(negedge clk);
        tx_enable = 1'b0;
        cts_n = 1'b1;
        parity_en = 1'b0;
      end
    join
    tx_enable = 1'b1;
    cts_sel = 1'b1;
    write_byte(8'h81);
    get_frame(8'h81, 1'b0, 1'b0);
    cts_sel = 1'b0;
    flow_off = 1'b1;
    write_byte(8'hC3);
    get_frame(8'hC3, 1'b0, 1'b0);

    // R8 back-to-back
    write_byte(8'h12);
    fork
      get_frame(8'h12, 1'b0, 1'b1);
      begin
        repeat (30) @(negedge clk);
        write_byte(8'hE7);
      end
    join
    get_frame(8'hE7, 1'b0, 1'b0);

    // R2 pacing by baud tick
    baud_tick = 1'b0;
    write_byte(8'hFF);
    @(negedge clk);
    repeat (40) @(negedge clk);
    chk(txd === 1'b0, "R2", "start bit held without ticks", txd, 0);
    baud_tick = 1'b1;
    repeat (15) @(negedge clk);
    chk(txd === 1'b0, "R2", "start bit after 15 ticks", txd, 0);
    @(negedge clk);
    chk(txd === 1'b1, "R2", "data after 16 ticks", txd, 1);
    begin
      int w = 0;
      while (tx_empty !== 1'b1 && w < 400) begin
        @(negedge clk);
        w++;
      end
    end
    chk(tx_empty === 1'b1, "R9", "pacing frame completes", tx_empty, 1);

    // R1 reset during a frame
    write_byte(8'h0F);
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(txd === 1'b1, "R1", "txd after mid-frame reset", txd, 1);
    chk(buf_empty === 1'b1, "R1", "buf_empty after mid-frame reset", buf_empty, 1);
    chk(tx_empty === 1'b1, "R1", "tx_empty after mid-frame reset", tx_empty, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule